// File: doc/BRIEF.md
# Interrupt Entry and Return Stacking Sequencer

This block handles the memory traffic of an 8-bit processor core when it takes an interrupt and when it returns from one. The core gives it a snapshot of the architectural registers and a pulse that marks each instruction boundary. When a request is eligible at a boundary, the sequencer writes the nine-byte register frame to a descending stack, one byte per cycle, on a byte-wide memory port. It then sets the mask bits in the live condition-code value, reads a two-byte service address from the vector table entry for the winning source, and presents the new program counter, stack pointer and condition codes to the core for one cycle.

A return command runs the same frame backwards. Nine ascending reads refill the registers, with the program counter bytes read last, and the restored set is handed back with a return flag. The two external request pins are synchronised inside the block. The software trap, capture-timer and periodic-tick requests arrive already synchronous from on-chip logic.

The condition-code byte uses bit 4 as the interrupt mask (I) and bit 6 as the non-maskable mask (X).

Top module: `irq_stack_seq`

## Requirements
- R1: `pin_irq` and `pin_nmi` each pass through two flip-flops. A pin that goes high in the same cycle as an `insn_done` pulse is not taken on that pulse. A pin held high for two rising edges before an `insn_done` cycle is taken.
- R2: An interrupt is accepted only in a cycle where `insn_done` is high and the sequencer is idle. Pending requests with `insn_done` low leave `busy` low.
- R3: `pin_irq`, `cap_req` and `tick_req` are ignored while snapshot CCR bit 4 is 1. `pin_nmi` is ignored while CCR bit 6 is 1. `soft_trap` is never masked.
- R4: Priority runs from highest to lowest as non-maskable pin, software trap, maskable pin, capture, tick. `ack_src` reports the winner as 0, 1, 2, 3 or 4 in that order.
- R5: Entry performs nine writes, one per cycle, at SP, SP-1, ... SP-8. The bytes go in this order: PC low, PC high, IY low, IY high, IX low, IX high, A, B, CCR.
- R6: The stored CCR byte is the unmodified snapshot value. After entry, `out_ccr` has bit 4 set, and bit 6 is also set when the source is the non-maskable pin.
- R7: The new PC high byte is read from the vector base and the low byte from base+1. The default bases are non-maskable FFF4h, software trap FFF6h, maskable pin FFF2h, capture FFECh and tick FF00h.
- R8: `busy` is high for exactly 11 cycles starting the cycle after acceptance. `load_valid` and `ack` then pulse together with `load_is_ret`=0 and `out_sp` = SP-9.
- R9: When idle, `ret_req` starts nine reads at SP+1 ... SP+9, in the order CCR, B, A, IX high, IX low, IY high, IY low, PC high, PC low. `busy` is high for 9 cycles. After that, `load_valid` pulses with `load_is_ret`=1, `ack`=0, the restored registers, and `out_sp` = SP+9.
- R10: If `ret_req` and an acceptable interrupt coincide at an idle boundary, the return is performed.
- R11: After reset, `busy`, `load_valid`, `ack`, `mem_wr` and `mem_rd` are low.
- R12: `mem_wr` and `mem_rd` are never high together, and `load_valid` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_irq | input | 1 | External maskable request, asynchronous, active high |
| pin_nmi | input | 1 | External non-maskable request, asynchronous, active high |
| soft_trap | input | 1 | Software trap request from decode |
| cap_req | input | 1 | Capture-timer request |
| tick_req | input | 1 | Periodic tick request |
| insn_done | input | 1 | Instruction boundary pulse |
| ret_req | input | 1 | Return-from-interrupt command |
| snap_pc | input | 16 | Program counter snapshot |
| snap_iy | input | 16 | IY snapshot |
| snap_ix | input | 16 | IX snapshot |
| snap_a | input | 8 | Accumulator A snapshot |
| snap_b | input | 8 | Accumulator B snapshot |
| snap_ccr | input | 8 | Condition codes snapshot |
| snap_sp | input | 16 | Stack pointer snapshot |
| mem_addr | output | 16 | Memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe (data returned in the same cycle) |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Sequence in progress |
| load_valid | output | 1 | Register set valid for the core, one cycle |
| load_is_ret | output | 1 | Register set comes from a return |
| ack | output | 1 | Interrupt entry completed |
| ack_src | output | 3 | Source code of the entry |
| out_pc | output | 16 | New or restored program counter |
| out_iy | output | 16 | IY to load |
| out_ix | output | 16 | IX to load |
| out_a | output | 8 | A to load |
| out_b | output | 8 | B to load |
| out_ccr | output | 8 | Condition codes to load |
| out_sp | output | 16 | Stack pointer to load |

## Verification
The bound assertions check on every cycle that reads and writes never overlap, that consecutive writes step the address down by one and consecutive reads step it up by one, and that `load_valid` lasts one cycle and never coincides with `busy`. They also check that every acknowledged entry carries the mask bits its source requires. The bench scenarios are the only way to show the actual byte order on the stack, the vector contents reaching `out_pc`, the masking and priority decisions, the two-edge synchroniser latency, and the precedence of a return over a coincident interrupt.

// File: rtl/isq_pkg.sv
// Shared definitions for the interrupt stacking sequencer.
// Assumes a byte-wide memory and a nine-byte register frame.
package isq_pkg;
    localparam int NSRC        = 5;
    localparam int SRC_W       = 3;
    localparam int FRAME_BYTES = 9;
    localparam int IDX_W       = 4;
    localparam int CCR_I_BIT   = 4;
    localparam int CCR_X_BIT   = 6;

    // Source codes double as priority rank (lower wins)
    localparam logic [SRC_W-1:0] SRC_NMI  = 3'd0;
    localparam logic [SRC_W-1:0] SRC_SOFT = 3'd1;
    localparam logic [SRC_W-1:0] SRC_PIN  = 3'd2;
    localparam logic [SRC_W-1:0] SRC_CAP  = 3'd3;
    localparam logic [SRC_W-1:0] SRC_TICK = 3'd4;

    // Frame byte slots, in push order
    localparam logic [IDX_W-1:0] FB_PCL = 4'd0;
    localparam logic [IDX_W-1:0] FB_PCH = 4'd1;
    localparam logic [IDX_W-1:0] FB_IYL = 4'd2;
    localparam logic [IDX_W-1:0] FB_IYH = 4'd3;
    localparam logic [IDX_W-1:0] FB_IXL = 4'd4;
    localparam logic [IDX_W-1:0] FB_IXH = 4'd5;
    localparam logic [IDX_W-1:0] FB_A   = 4'd6;
    localparam logic [IDX_W-1:0] FB_B   = 4'd7;
    localparam logic [IDX_W-1:0] FB_CCR = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VHI,
        ST_VLO,
        ST_POP,
        ST_FIN
    } seq_state_e;
endpackage

// File: rtl/isq_sync.sv
// Multi-stage synchroniser for a bank of asynchronous request pins.
// Assumes the inputs are level signals that stay high until serviced.
module isq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift each pin through its own flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[g]};
            end
        end

        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/isq_arbiter.sv
// Masks requests with the CCR mask bits and picks the highest-priority
// one. Index 0 has the highest priority. Purely combinational.
module isq_arbiter
    import isq_pkg::*;
#(
    parameter int              N       = NSRC,
    parameter logic [N-1:0]    X_GATED = 5'b00001,
    parameter logic [N-1:0]    I_GATED = 5'b11100
) (
    input  logic [N-1:0]     req,
    input  logic             mask_i,
    input  logic             mask_x,
    output logic             hit,
    output logic [SRC_W-1:0] src
);
    logic [N-1:0] eligible;

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign eligible[g] = req[g]
                           & ~(X_GATED[g] & mask_x)
                           & ~(I_GATED[g] & mask_i);
    end

    // Fixed-priority pick: the lowest eligible index wins
    always_comb begin
        src = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eligible[i]) src = SRC_W'(i);
        end
    end

    assign hit = |eligible;
endmodule

// File: rtl/irq_stack_seq.sv
// Interrupt entry and return stacking sequencer.
// On entry: stacks nine bytes downward, sets mask bits, fetches a
// two-byte vector. On return: reads nine bytes upward, restores them.
// Assumes memory read data is valid in the same cycle as mem_rd.
module irq_stack_seq
    import isq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          SYNC_STG  = 2,
    parameter logic [15:0] VEC_NMI   = 16'hFFF4,
    parameter logic [15:0] VEC_SOFT  = 16'hFFF6,
    parameter logic [15:0] VEC_PIN   = 16'hFFF2,
    parameter logic [15:0] VEC_CAP   = 16'hFFEC,
    parameter logic [15:0] VEC_TICK  = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_irq,
    input  logic              pin_nmi,
    input  logic              soft_trap,
    input  logic              cap_req,
    input  logic              tick_req,
    input  logic              insn_done,
    input  logic              ret_req,
    input  logic [15:0]       snap_pc,
    input  logic [15:0]       snap_iy,
    input  logic [15:0]       snap_ix,
    input  logic [7:0]        snap_a,
    input  logic [7:0]        snap_b,
    input  logic [7:0]        snap_ccr,
    input  logic [ADDR_W-1:0] snap_sp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              load_valid,
    output logic              load_is_ret,
    output logic              ack,
    output logic [SRC_W-1:0]  ack_src,
    output logic [15:0]       out_pc,
    output logic [15:0]       out_iy,
    output logic [15:0]       out_ix,
    output logic [7:0]        out_a,
    output logic [7:0]        out_b,
    output logic [7:0]        out_ccr,
    output logic [ADDR_W-1:0] out_sp
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    seq_state_e          state;
    logic [IDX_W-1:0]    idx;
    logic [ADDR_W-1:0]   sp;
    logic [SRC_W-1:0]    src_q;
    logic                is_ret_q;
    logic [7:0]          frame [FRAME_BYTES];
    logic [1:0]          pins_s;
    logic [NSRC-1:0]     req_vec;
    logic                arb_hit;
    logic [SRC_W-1:0]    arb_src;
    logic [ADDR_W-1:0]   vbase;
    logic [7:0]          mask_set;

    isq_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pin_nmi, pin_irq}),
        .sync_out (pins_s)
    );

    // Request vector ordered by priority rank
    assign req_vec = {tick_req, cap_req, pins_s[0], soft_trap, pins_s[1]};

    isq_arbiter #(.N(NSRC)) u_arb (
        .req    (req_vec),
        .mask_i (snap_ccr[CCR_I_BIT]),
        .mask_x (snap_ccr[CCR_X_BIT]),
        .hit    (arb_hit),
        .src    (arb_src)
    );

    // Vector table base for the captured source
    always_comb begin
        case (src_q)
            SRC_NMI:  vbase = ADDR_W'(VEC_NMI);
            SRC_SOFT: vbase = ADDR_W'(VEC_SOFT);
            SRC_PIN:  vbase = ADDR_W'(VEC_PIN);
            SRC_CAP:  vbase = ADDR_W'(VEC_CAP);
            default:  vbase = ADDR_W'(VEC_TICK);
        endcase
    end

    // Mask bits applied once the CCR byte is on the stack
    always_comb begin
        mask_set = 8'h00;
        mask_set[CCR_I_BIT] = 1'b1;
        if (src_q == SRC_NMI) mask_set[CCR_X_BIT] = 1'b1;
    end

    // Sequencer state, stack pointer and frame register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            sp       <= '0;
            src_q    <= '0;
            is_ret_q <= 1'b0;
            for (int i = 0; i < FRAME_BYTES; i++) frame[i] <= 8'h00;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ret_req) begin
                        state    <= ST_POP;
                        idx      <= LAST_IDX;
                        sp       <= snap_sp;
                        is_ret_q <= 1'b1;
                    end else if (insn_done && arb_hit) begin
                        state         <= ST_PUSH;
                        idx           <= '0;
                        sp            <= snap_sp;
                        src_q         <= arb_src;
                        is_ret_q      <= 1'b0;
                        frame[FB_PCL] <= snap_pc[7:0];
                        frame[FB_PCH] <= snap_pc[15:8];
                        frame[FB_IYL] <= snap_iy[7:0];
                        frame[FB_IYH] <= snap_iy[15:8];
                        frame[FB_IXL] <= snap_ix[7:0];
                        frame[FB_IXH] <= snap_ix[15:8];
                        frame[FB_A]   <= snap_a;
                        frame[FB_B]   <= snap_b;
                        frame[FB_CCR] <= snap_ccr;
                    end
                end
                ST_PUSH: begin
                    sp <= sp - ADDR_W'(1);
                    if (idx == LAST_IDX) begin
                        state         <= ST_VHI;
                        frame[FB_CCR] <= frame[FB_CCR] | mask_set;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_VHI: begin
                    frame[FB_PCH] <= mem_rdata;
                    state         <= ST_VLO;
                end
                ST_VLO: begin
                    frame[FB_PCL] <= mem_rdata;
                    state         <= ST_FIN;
                end
                ST_POP: begin
                    frame[idx] <= mem_rdata;
                    sp         <= sp + ADDR_W'(1);
                    if (idx == '0) state <= ST_FIN;
                    else           idx   <= idx - IDX_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive per state
    always_comb begin
        mem_addr  = '0;
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        mem_wdata = 8'h00;
        case (state)
            ST_PUSH: begin
                mem_addr  = sp;
                mem_wr    = 1'b1;
                mem_wdata = frame[idx];
            end
            ST_VHI: begin
                mem_addr = vbase;
                mem_rd   = 1'b1;
            end
            ST_VLO: begin
                mem_addr = vbase + ADDR_W'(1);
                mem_rd   = 1'b1;
            end
            ST_POP: begin
                mem_addr = sp + ADDR_W'(1);
                mem_rd   = 1'b1;
            end
            default: ;
        endcase
    end

    // Status and register outputs
    assign busy        = (state == ST_PUSH) || (state == ST_VHI) ||
                         (state == ST_VLO)  || (state == ST_POP);
    assign load_valid  = (state == ST_FIN);
    assign load_is_ret = is_ret_q;
    assign ack         = (state == ST_FIN) && !is_ret_q;
    assign ack_src     = src_q;
    assign out_pc      = {frame[FB_PCH], frame[FB_PCL]};
    assign out_iy      = {frame[FB_IYH], frame[FB_IYL]};
    assign out_ix      = {frame[FB_IXH], frame[FB_IXL]};
    assign out_a       = frame[FB_A];
    assign out_b       = frame[FB_B];
    assign out_ccr     = frame[FB_CCR];
    assign out_sp      = sp;
endmodule

// File: rtl/isq_checker.sv
// Cycle-by-cycle properties of the stacking sequencer, bound to the top.
module isq_checker
    import isq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              load_valid,
    input logic              load_is_ret,
    input logic              ack,
    input logic [SRC_W-1:0]  ack_src,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        out_ccr
);
    assert_rw_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    assert_load_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> !load_valid);

    assert_busy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && load_valid));

    assert_push_desc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - ADDR_W'(1)));

    assert_read_asc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_ack_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (load_valid && !load_is_ret));

    assert_mask_i_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> out_ccr[CCR_I_BIT]);

    assert_mask_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_src == SRC_NMI) |-> out_ccr[CCR_X_BIT]);

    assert_src_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ack_src < SRC_W'(NSRC)));
endmodule

bind irq_stack_seq isq_checker #(.ADDR_W(ADDR_W)) u_isq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .load_valid  (load_valid),
    .load_is_ret (load_is_ret),
    .ack         (ack),
    .ack_src     (ack_src),
    .mem_wr      (mem_wr),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .out_ccr     (out_ccr)
);

// File: tb/irq_stack_seq_test.sv
// Self-checking bench: vector table walk, then directed corner cases.
module irq_stack_seq_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_irq = 0, pin_nmi = 0, soft_trap = 0, cap_req = 0, tick_req = 0;
    logic insn_done = 0, ret_req = 0;
    logic [15:0] snap_pc = 16'h1234, snap_iy = 16'h5678, snap_ix = 16'h9ABC;
    logic [7:0]  snap_a = 8'hDE, snap_b = 8'hF0, snap_ccr = 8'h00;
    logic [15:0] snap_sp = 16'h01F0;
    logic [15:0] mem_addr;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, load_valid, load_is_ret, ack;
    logic [2:0]  ack_src;
    logic [15:0] out_pc, out_iy, out_ix, out_sp;
    logic [7:0]  out_a, out_b, out_ccr;

    logic [7:0] stk [256];
    int errors = 0;
    int checks = 0;
    int cycles = 0;

    irq_stack_seq uut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Stack page 01xxh is RAM; the top page returns addr low byte ^ A5h
    assign mem_rdata = (mem_addr >= 16'hFF00) ? (mem_addr[7:0] ^ 8'hA5)
                                              : stk[mem_addr[7:0]];
    always @(posedge clk)
        if (mem_wr && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] vbase(input logic [2:0] s);
        case (s)
            3'd0:    return 16'hFFF4;
            3'd1:    return 16'hFFF6;
            3'd2:    return 16'hFFF2;
            3'd3:    return 16'hFFEC;
            default: return 16'hFF00;
        endcase
    endfunction

    task automatic clear_reqs();
        {pin_nmi, soft_trap, pin_irq, cap_req, tick_req} = 5'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_busy(output int n);
        n = 0;
        while (busy && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic prefill_frame();
        stk[8'hE8] = 8'h2C; stk[8'hE9] = 8'h11; stk[8'hEA] = 8'h22;
        stk[8'hEB] = 8'h33; stk[8'hEC] = 8'h44; stk[8'hED] = 8'h55;
        stk[8'hEE] = 8'h66; stk[8'hEF] = 8'h77; stk[8'hF0] = 8'h88;
    endtask

    // {nmi,soft,irq,cap,tick}, ccr, taken, src
    localparam logic [16:0] VECS [10] = '{
        {5'b00100, 8'h00, 1'b1, 3'd2},
        {5'b00100, 8'h10, 1'b0, 3'd0},
        {5'b10000, 8'h10, 1'b1, 3'd0},
        {5'b10000, 8'h40, 1'b0, 3'd0},
        {5'b10100, 8'h00, 1'b1, 3'd0},
        {5'b01000, 8'h50, 1'b1, 3'd1},
        {5'b00011, 8'h00, 1'b1, 3'd3},
        {5'b00001, 8'h0F, 1'b1, 3'd4},
        {5'b01100, 8'h00, 1'b1, 3'd1},
        {5'b00010, 8'h10, 1'b0, 3'd0}
    };

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!busy && !load_valid && !ack && !mem_wr && !mem_rd, "R11 reset",
            {busy, load_valid, ack, mem_wr, mem_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            logic [4:0]  rq;
            logic [7:0]  ccr;
            logic        taken;
            logic [2:0]  es;
            logic [7:0]  eccr;
            logic [15:0] b;
            logic [15:0] epc;
            logic [7:0]  ebytes [9];
            bit          stk_ok;
            int          n;
            {rq, ccr, taken, es} = VECS[v];
            snap_ccr = ccr;
            snap_sp  = 16'h01F0;
            {pin_nmi, soft_trap, pin_irq, cap_req, tick_req} = rq;
            repeat (3) @(negedge clk);
            insn_done = 1'b1;
            @(negedge clk);
            insn_done = 1'b0;
            if (!taken) begin
                // R3: masked request leaves the sequencer idle
                repeat (2) @(negedge clk);
                chk(!busy && !load_valid, "R3 masked ignored",
                    {busy, load_valid}, 0);
            end else begin
                run_busy(n);
                chk(n == 11, "R8 busy length", n, 11);
                chk(load_valid && ack && !load_is_ret, "R8 entry pulse",
                    {load_valid, ack, load_is_ret}, 3'b110);
                chk(ack_src == es, "R4 source priority", ack_src, es);
                b    = vbase(es);
                epc  = {b[7:0] ^ 8'hA5, (b[7:0] + 8'd1) ^ 8'hA5};
                chk(out_pc == epc, "R7 vector fetch", out_pc, epc);
                eccr = ccr | 8'h10 | ((es == 3'd0) ? 8'h40 : 8'h00);
                chk(out_ccr == eccr, "R6 mask bits", out_ccr, eccr);
                chk(out_sp == 16'h01E7, "R8 stack pointer", out_sp, 16'h01E7);
                ebytes = '{8'h34, 8'h12, 8'h78, 8'h56, 8'hBC, 8'h9A,
                           8'hDE, 8'hF0, ccr};
                stk_ok = 1'b1;
                for (int k = 0; k < 9; k++)
                    if (stk[8'hF0 - k] != ebytes[k]) stk_ok = 1'b0;
                chk(stk_ok, "R5 push order", {stk[8'hE8], stk[8'hF0]},
                    {ccr, 8'h34});
                @(negedge clk);
                chk(!load_valid, "R12 single pulse", load_valid, 0);
            end
            clear_reqs();
        end

        // R1: pin seen only after two edges
        snap_ccr  = 8'h00;
        pin_irq   = 1'b1;
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk(!busy, "R1 sync latency early", busy, 0);
        @(negedge clk);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk(busy, "R1 sync latency taken", busy, 1);
        begin
            int n;
            run_busy(n);
        end
        @(negedge clk);
        // R2: pending with no boundary
        repeat (5) @(negedge clk);
        chk(!busy && !load_valid, "R2 needs boundary", busy, 0);
        clear_reqs();

        // R9: return restores in reverse order
        prefill_frame();
        snap_sp = 16'h01E7;
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        begin
            int n;
            run_busy(n);
            chk(n == 9, "R9 busy length", n, 9);
        end
        chk(load_valid && load_is_ret && !ack, "R9 return pulse",
            {load_valid, load_is_ret, ack}, 3'b110);
        chk(out_pc == 16'h7788, "R9 restored pc", out_pc, 16'h7788);
        chk(out_ix == 16'h3344 && out_iy == 16'h5566, "R9 restored index",
            {out_ix, out_iy}, 32'h33445566);
        chk(out_a == 8'h22 && out_b == 8'h11 && out_ccr == 8'h2C,
            "R9 restored acc/ccr", {out_a, out_b, out_ccr}, 24'h22112C);
        chk(out_sp == 16'h01F0, "R9 stack pointer", out_sp, 16'h01F0);
        @(negedge clk);

        // R10: return wins over a coincident interrupt
        prefill_frame();
        snap_ccr = 8'h00;
        pin_irq  = 1'b1;
        repeat (3) @(negedge clk);
        ret_req   = 1'b1;
        insn_done = 1'b1;
        @(negedge clk);
        ret_req   = 1'b0;
        insn_done = 1'b0;
        begin
            int n;
            run_busy(n);
            chk(n == 9, "R10 return chosen length", n, 9);
        end
        chk(load_valid && load_is_ret, "R10 return precedence",
            {load_valid, load_is_ret}, 2'b11);
        clear_reqs();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule